// File: doc/BRIEF.md
# Limb-Serial Big Integer Adder

This block adds two wide unsigned integers one limb at a time. Each valid cycle it accepts one limb from each operand, adds them together with a stored carry bit, and returns the low limb of the result one cycle later. The limbs must arrive least significant first, so the carry out of each step feeds the step for the next, more significant limb.

The carry bit is persistent state that the surrounding logic can see. It is never cleared on its own when a new operation begins: the caller pulses a separate clear strobe before the first limb, and can instead leave it set to extend an earlier sum. After the last limb the bit holds the carry out of the whole addition. A limb counter, loaded with the number of limbs per operation, raises a one-cycle done pulse that comes out with the sum of the final limb.

Top module: `bigint_limb_adder`

## Requirements
- R1: While reset is high and in the first cycle after it, `carry_flag`, `sum_valid` and `done` are 0.
- R2: A cycle with `in_valid` high makes `sum_valid` 1 in the next cycle, with `sum_limb` equal to the low LIMB_W bits of `limb_a + limb_b + carry-in`. A cycle with `in_valid` low makes `sum_valid` 0 in the next cycle.
- R3: After a valid step, `carry_flag` holds the carry out (bit LIMB_W) of that step's sum.
- R4: A cycle with neither `in_valid` nor `carry_clr` leaves `carry_flag` unchanged.
- R5: A `carry_clr` pulse with no valid limb makes `carry_flag` 0 in the next cycle.
- R6: When `carry_clr` and `in_valid` are high in the same cycle, the clear acts first: the step uses a carry-in of 0.
- R7: The carry is not reset when an operation starts. A new operation begun without `carry_clr` adds in the carry left by the one before.
- R8: `done` is 1 for exactly the cycle that carries the sum of the `num_limbs`-th valid limb counted from reset or from the previous done. A `num_limbs` of 0 acts as 1.
- R9: Over a chain of limbs fed least significant first after a clear, the `sum_limb` outputs, placed in order, form the full-width sum, and the final `carry_flag` is its top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carry_clr | input | 1 | Strobe that sets the carry bit to zero |
| num_limbs | input | CNT_W | Number of limbs in each operation |
| in_valid | input | 1 | A limb pair is present this cycle |
| limb_a | input | LIMB_W | Limb of the first operand |
| limb_b | input | LIMB_W | Limb of the second operand |
| sum_valid | output | 1 | `sum_limb` holds a result |
| sum_limb | output | LIMB_W | Low limb of the step result |
| carry_flag | output | 1 | Stored carry bit |
| done | output | 1 | Pulses with the last limb's sum |

## Verification
Each result comes from a single register stage. `sum_limb`, `sum_valid`, `done` and `carry_flag` therefore all show the effect of the inputs present at one rising edge, and nothing else. The bench drives inputs on the falling edge and moves its model forward by exactly one step for each rising edge. It compares every output on the next falling edge, so each comparison falls in the single cycle where that result is due. The full-width check builds the 256-bit result from the four limb sums, read as they appear, and compares it with a wide sum the bench computes itself.

// File: rtl/bigint_add_pkg.sv
package bigint_add_pkg;

    localparam int DEF_LIMB_W = 64;
    localparam int DEF_CNT_W  = 8;

    // What the carry register does this cycle
    typedef enum logic [1:0] {
        CF_HOLD  = 2'd0,
        CF_CLEAR = 2'd1,
        CF_LOAD  = 2'd2
    } cf_op_e;

    // A valid step takes priority; a clear alone zeroes; else hold
    function automatic cf_op_e pick_cf_op(input logic step, input logic clr);
        if (step)
            return CF_LOAD;
        else if (clr)
            return CF_CLEAR;
        else
            return CF_HOLD;
    endfunction

    // Carry-in after a possible same-cycle clear
    function automatic logic eff_carry(input logic clr, input logic flag);
        return clr ? 1'b0 : flag;
    endfunction

endpackage

// File: rtl/blc_limb_alu.sv
module blc_limb_alu #(
    parameter int LIMB_W = bigint_add_pkg::DEF_LIMB_W
) (
    input  logic [LIMB_W-1:0] a,
    input  logic [LIMB_W-1:0] b,
    input  logic              cin,
    output logic [LIMB_W-1:0] sum,
    output logic              cout
);
    localparam int WIDE_W = LIMB_W + 1;

    logic [WIDE_W-1:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{LIMB_W{1'b0}}, cin};
        sum  = wide[LIMB_W-1:0];
        cout = wide[LIMB_W];
    end
endmodule

// File: rtl/blc_carry_flag.sv
module blc_carry_flag
    import bigint_add_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cf_op_e op,
    input  logic   cout,
    output logic   flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            unique case (op)
                CF_LOAD:  flag <= cout;
                CF_CLEAR: flag <= 1'b0;
                default:  flag <= flag;
            endcase
        end
    end
endmodule

// File: rtl/blc_step_counter.sv
module blc_step_counter #(
    parameter int CNT_W = bigint_add_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] num_limbs,
    output logic             last
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [EXT_W-1:0] next_cnt;

    always_comb begin
        next_cnt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        // a count of zero behaves like one
        last     = next_cnt >= {1'b0, num_limbs};
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : next_cnt[CNT_W-1:0];
    end
endmodule

// File: rtl/bigint_limb_adder.sv
module bigint_limb_adder
    import bigint_add_pkg::*;
#(
    parameter int LIMB_W = DEF_LIMB_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              carry_clr,
    input  logic [CNT_W-1:0]  num_limbs,
    input  logic              in_valid,
    input  logic [LIMB_W-1:0] limb_a,
    input  logic [LIMB_W-1:0] limb_b,
    output logic              sum_valid,
    output logic [LIMB_W-1:0] sum_limb,
    output logic              carry_flag,
    output logic              done
);
    logic              cin;
    logic [LIMB_W-1:0] step_sum;
    logic              step_cout;
    logic              step_last;
    cf_op_e            cf_op;

    always_comb begin
        cin   = eff_carry(carry_clr, carry_flag);
        cf_op = pick_cf_op(in_valid, carry_clr);
    end

    blc_limb_alu #(.LIMB_W(LIMB_W)) u_alu (
        .a    (limb_a),
        .b    (limb_b),
        .cin  (cin),
        .sum  (step_sum),
        .cout (step_cout)
    );

    blc_carry_flag u_cf (
        .clk  (clk),
        .rst  (rst),
        .op   (cf_op),
        .cout (step_cout),
        .flag (carry_flag)
    );

    blc_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (in_valid),
        .num_limbs (num_limbs),
        .last      (step_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_valid <= 1'b0;
            done      <= 1'b0;
            sum_limb  <= '0;
        end else begin
            sum_valid <= in_valid;
            done      <= in_valid && step_last;
            if (in_valid)
                sum_limb <= step_sum;
        end
    end
endmodule

// File: rtl/bigint_limb_adder_checker.sv
module bigint_limb_adder_checker #(
    parameter int LIMB_W = 64,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              carry_clr,
    input logic [CNT_W-1:0]  num_limbs,
    input logic              in_valid,
    input logic [LIMB_W-1:0] limb_a,
    input logic [LIMB_W-1:0] limb_b,
    input logic              sum_valid,
    input logic [LIMB_W-1:0] sum_limb,
    input logic              carry_flag,
    input logic              done
);
    logic started;
    always_ff @(posedge clk) started <= 1'b1;

    always_ff @(posedge clk) begin
        if (started && $past(rst)) begin
            assert_reset_clear_R1: assert (!carry_flag && !sum_valid && !done)
                else $error("R1 outputs not cleared after reset");
        end
    end

    property p_valid_follow;
        @(posedge clk) disable iff (rst) in_valid |=> sum_valid;
    endproperty
    assert_valid_follow_R2: assert property (p_valid_follow);

    property p_idle_follow;
        @(posedge clk) disable iff (rst) !in_valid |=> !sum_valid;
    endproperty
    assert_idle_follow_R2: assert property (p_idle_follow);

    property p_step_math;
        @(posedge clk) disable iff (rst) in_valid |=>
            ({carry_flag, sum_limb} == ({1'b0, $past(limb_a)} + {1'b0, $past(limb_b)}
                + {{LIMB_W{1'b0}}, ($past(carry_clr) ? 1'b0 : $past(carry_flag))}));
    endproperty
    assert_step_math_R3: assert property (p_step_math);

    property p_hold;
        @(posedge clk) disable iff (rst) (!in_valid && !carry_clr) |=> $stable(carry_flag);
    endproperty
    assert_carry_hold_R4: assert property (p_hold);

    property p_clear;
        @(posedge clk) disable iff (rst) (carry_clr && !in_valid) |=> !carry_flag;
    endproperty
    assert_carry_clear_R5: assert property (p_clear);

    property p_done_with_sum;
        @(posedge clk) disable iff (rst) done |-> sum_valid;
    endproperty
    assert_done_with_sum_R8: assert property (p_done_with_sum);
endmodule

bind bigint_limb_adder bigint_limb_adder_checker #(.LIMB_W(LIMB_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_bigint_limb_adder.sv
module tb_bigint_limb_adder;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 64;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          carry_clr;
    logic [CW-1:0] num_limbs;
    logic          in_valid;
    logic [LW-1:0] limb_a, limb_b;
    logic          sum_valid, carry_flag, done;
    logic [LW-1:0] sum_limb;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit            m_carry;
    int            m_cnt;
    bit            e_sv, e_done;
    logic [LW-1:0] e_sum;

    always #(CLK_PERIOD/2) clk = ~clk;

    bigint_limb_adder #(.LIMB_W(LW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .carry_clr(carry_clr), .num_limbs(num_limbs),
        .in_valid(in_valid), .limb_a(limb_a), .limb_b(limb_b),
        .sum_valid(sum_valid), .sum_limb(sum_limb), .carry_flag(carry_flag), .done(done)
    );

    task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at falling edge, model one step, compare at next falling edge
    task automatic cyc(input bit v, input logic [LW-1:0] a, input logic [LW-1:0] b,
                       input bit clr, input string tag);
        logic [LW:0] w;
        int lim;
        in_valid = v; limb_a = a; limb_b = b; carry_clr = clr;
        lim = (num_limbs == 0) ? 1 : int'(num_limbs);
        if (v) begin
            w = {1'b0, a} + {1'b0, b} + {{LW{1'b0}}, (clr ? 1'b0 : m_carry)};
            e_sum = w[LW-1:0]; m_carry = w[LW]; e_sv = 1; m_cnt++;
            e_done = (m_cnt >= lim);
            if (e_done) m_cnt = 0;
        end else begin
            e_sv = 0; e_done = 0;
            if (clr) m_carry = 0;
        end
        @(posedge clk); @(negedge clk);
        chk({tag, " R2 sum_valid"}, LW'(sum_valid), LW'(e_sv));
        chk({tag, " R8 done"}, LW'(done), LW'(e_done));
        chk({tag, " R3 carry_flag"}, LW'(carry_flag), LW'(m_carry));
        if (e_sv) chk({tag, " R2 sum_limb"}, sum_limb, e_sum);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [255:0] wa, wb, got;
        logic [256:0] full;
        rst = 1; carry_clr = 0; in_valid = 0; limb_a = '0; limb_b = '0; num_limbs = 4;
        m_carry = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        chk("R1 carry in reset", LW'(carry_flag), '0);
        chk("R1 valid in reset", LW'(sum_valid), '0);
        rst = 0;
        cyc(0, '0, '0, 0, "R1 idle");

        // R9: four random limbs after a clear, LSB first
        for (int t = 0; t < 3; t++) begin
            wa = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            wb = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            if (t == 2) begin wa = '1; wb = 256'd1; end
            cyc(0, '0, '0, 1, "R5 clear");
            for (int i = 0; i < 4; i++) begin
                cyc(1, wa[i*LW +: LW], wb[i*LW +: LW], 0, "R9 chain");
                got[i*LW +: LW] = sum_limb;
            end
            full = {1'b0, wa} + {1'b0, wb};
            chk("R9 full sum low", got[LW-1:0], full[LW-1:0]);
            chk("R9 full sum top limb", got[255:192], full[255:192]);
            chk("R9 final carry", LW'(carry_flag), LW'(full[256]));
        end

        // R4: idle cycles hold a set carry
        cyc(1, '1, 64'd1, 1, "R6 clr+valid");
        cyc(0, '0, '0, 0, "R4 hold");
        cyc(0, '0, '0, 0, "R4 hold");
        chk("R4 carry still set", LW'(carry_flag), 64'd1);

        // R7: next op without clear uses the stored carry
        cyc(1, 64'd5, 64'd6, 0, "R7 persist");
        chk("R7 sum includes old carry", sum_limb, 64'd12);

        // R6: clear and valid together, carry set
        cyc(1, '1, '1, 0, "R6 setup");
        cyc(1, 64'd2, 64'd3, 1, "R6 clr+valid");
        chk("R6 carry-in ignored", sum_limb, 64'd5);

        // R8: two-limb ops with gaps, then zero count
        rst = 1; @(negedge clk); rst = 0; m_carry = 0; m_cnt = 0;
        num_limbs = 2;
        cyc(1, 64'd1, 64'd1, 0, "R8 n2");
        cyc(0, '0, '0, 0, "R8 gap");
        cyc(1, 64'd2, 64'd2, 0, "R8 n2 last");
        cyc(1, 64'd3, 64'd3, 0, "R8 n2");
        cyc(1, 64'd4, 64'd4, 0, "R8 n2 last");
        num_limbs = 0;
        cyc(1, 64'd7, 64'd7, 0, "R8 zero count");
        cyc(1, 64'd8, 64'd8, 0, "R8 zero count");
        cyc(0, '0, '0, 0, "R8 idle");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule